// File: doc/BRIEF.md
# Fault-Injecting SRAM Array Model

This block is a synthesizable memory array arranged as rows (word lines) and columns, with one word per address. It carries a switchable model of a dynamic read-destructive fault on one chosen bit of one chosen word. With the fault enabled, a marginal cell keeps its value through a first read. After enough read-type stress, its stored level gives way and inverts. A memory test controller, such as a march sequencer, can run against the array and show whether its address ordering and operation sequence catch this class of defect.

The fault is armed when the faulty bit is written with its sensitive value. From then on, each access to the faulty row counts as one stress: a read of the faulty word, or a read or write of any other column on that row. Selecting another column on an open row leaves the faulty cell's bit lines precharged, and that load is equivalent to a read. The bit inverts after the third stress, so one write followed by one read never shows the fault. An access to another row disarms the fault. So does writing the non-sensitive value into the faulty bit. The sensitive polarity is selectable, so a defect on either storage node can be modelled.

Top module: `sram_drf_array`

## Requirements
- R1: With `flt_en` low, every word reads back the value last written to it, so the block acts as an ideal RAM.
- R2: The address holds the row index in its upper ROW_BITS bits and the column index in its lower COL_BITS bits. In the bench configuration (2+2 bits), address 9 is row 2, column 1, and addresses 8, 10 and 11 share that row.
- R3: A read strobe (`req_valid`=1, `req_we`=0) gives `rvalid`=1 with `rdata` on the cycle after it. After reset, and in every cycle that does not follow a read strobe, `rvalid` is 0.
- R4: A write that puts the sensitive value (`flt_pol`) into bit `flt_bit` of the faulty word arms the fault. The stored value still reads back correctly on the first and second stress that follow.
- R5: The third stress after arming inverts the faulty bit. A read that is itself that third stress still returns the old value, and later reads return the bit inverted. The other bits of the word are unchanged.
- R6: Reads and writes to other columns of the faulty row count as stresses, in the same way as reads of the faulty word.
- R7: An access to any other row, or a write of the non-sensitive value into the faulty bit, disarms the fault and clears the stress count. Further reads then never invert the bit until it is armed again.
- R8: With `flt_pol`=0, writing a 0 into the faulty bit arms the fault, and after three stresses the bit reads as 1.
- R9: An inverted bit stays inverted until the faulty word is written again. A rewrite stores the new data.
- R10: Pulling `flt_en` low removes any inversion and any arming. Reads then return the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in upper field |
| req_wdata | input | DW | Write data |
| flt_en | input | 1 | Fault model enable |
| flt_row | input | ROW_BITS | Row of the faulty word |
| flt_col | input | COL_BITS | Column of the faulty word |
| flt_bit | input | $clog2(DW) | Bit of the faulty word that is marginal |
| flt_pol | input | 1 | Sensitive value of the faulty bit |
| rvalid | output | 1 | Read data valid |
| rdata | output | DW | Read data |

## Verification
A stress count that is off by one, or one that misses a row-mate access, moves the inversion by exactly one access. It then shows on the next read of the faulty word as a single wrong bit, either one read early or a read late. An arming state that survives an access to a foreign row shows only later, as an inversion where the data should hold. For that reason the bench always follows a disarming access with at least four reads of the faulty word. A stale inversion flag shows up on the first read after a rewrite or after the fault is disabled.

// File: rtl/sram_drf_pkg.sv
package sram_drf_pkg;

  // Classification of one access as seen by the faulty cell
  typedef enum logic [1:0] {
    EV_NONE        = 2'd0,  // no strobe this cycle
    EV_FOREIGN_ROW = 2'd1,  // another word line opened
    EV_CELL_WRITE  = 2'd2,  // the faulty word itself is written
    EV_ROW_STRESS  = 2'd3   // read of faulty word, or any access to a row-mate
  } drf_event_e;

endpackage

// File: rtl/sram_drf_decode.sv
module sram_drf_decode
  import sram_drf_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ROW_BITS-1:0] flt_row,
  input  logic [COL_BITS-1:0] flt_col,
  output drf_event_e          ev,
  output logic                cell_hit
);

  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic                row_hit;

  assign row_idx  = req_addr[ADDR_W-1:COL_BITS];
  assign col_idx  = req_addr[COL_BITS-1:0];
  assign row_hit  = (row_idx == flt_row);
  assign cell_hit = req_valid && row_hit && (col_idx == flt_col);

  always_comb begin
    if (!req_valid)               ev = EV_NONE;
    else if (!row_hit)            ev = EV_FOREIGN_ROW;
    else if (cell_hit && req_we)  ev = EV_CELL_WRITE;
    else                          ev = EV_ROW_STRESS;
  end

endmodule

// File: rtl/sram_drf_stress.sv
module sram_drf_stress
  import sram_drf_pkg::*;
#(
  parameter int THR = 3,
  localparam int CW = $clog2(THR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  drf_event_e    ev,
  input  logic          sens_match,
  output logic          armed,
  output logic [CW-1:0] cnt,
  output logic          corrupt
);

  localparam logic [CW-1:0] LAST = CW'(THR - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed   <= 1'b0;
      cnt     <= '0;
      corrupt <= 1'b0;
    end else begin
      unique case (ev)
        EV_NONE: ;
        EV_FOREIGN_ROW: begin
          armed <= 1'b0;
          cnt   <= '0;
        end
        EV_CELL_WRITE: begin
          armed   <= sens_match;
          cnt     <= '0;
          corrupt <= 1'b0;
        end
        EV_ROW_STRESS: begin
          if (armed) begin
            if (cnt == LAST) begin
              armed   <= 1'b0;
              cnt     <= '0;
              corrupt <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sram_drf_store.sv
module sram_drf_store #(
  parameter int ADDR_W = 8,
  parameter int DW     = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rd_q <= mem[addr];
  end

endmodule

// File: rtl/sram_drf_array.sv
module sram_drf_array
  import sram_drf_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DW       = 8,
  parameter int THR      = 3,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int BIT_W   = (DW > 1) ? $clog2(DW) : 1,
  localparam int CW      = $clog2(THR + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic                flt_en,
  input  logic [ROW_BITS-1:0] flt_row,
  input  logic [COL_BITS-1:0] flt_col,
  input  logic [BIT_W-1:0]    flt_bit,
  input  logic                flt_pol,
  output logic                rvalid,
  output logic [DW-1:0]       rdata
);

  drf_event_e    ev_w;
  logic          cell_hit_w;
  logic          sens_match_w;
  logic          armed_w;
  logic [CW-1:0] cnt_w;
  logic          corrupt_w;
  logic [DW-1:0] rd_raw_q;
  logic          rd_strobe;

  logic             patch_q;
  logic [BIT_W-1:0] patch_bit_q;
  logic             patch_val_q;

  assign rd_strobe    = req_valid && !req_we;
  assign sens_match_w = (req_wdata[flt_bit] == flt_pol);

  sram_drf_decode #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) decode_i (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .flt_row   (flt_row),
    .flt_col   (flt_col),
    .ev        (ev_w),
    .cell_hit  (cell_hit_w)
  );

  sram_drf_stress #(
    .THR (THR)
  ) stress_i (
    .clk        (clk),
    .rst        (rst),
    .en         (flt_en),
    .ev         (ev_w),
    .sens_match (sens_match_w),
    .armed      (armed_w),
    .cnt        (cnt_w),
    .corrupt    (corrupt_w)
  );

  sram_drf_store #(
    .ADDR_W (ADDR_W),
    .DW     (DW)
  ) store_i (
    .clk   (clk),
    .wr_en (req_valid && req_we),
    .rd_en (rd_strobe),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rd_q  (rd_raw_q)
  );

  // Read-side overlay: the flipped level lives beside the array, so the
  // array keeps a single write port.
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid      <= 1'b0;
      patch_q     <= 1'b0;
      patch_bit_q <= '0;
      patch_val_q <= 1'b0;
    end else begin
      rvalid <= rd_strobe;
      if (rd_strobe) begin
        patch_q     <= flt_en && corrupt_w && cell_hit_w;
        patch_bit_q <= flt_bit;
        patch_val_q <= ~flt_pol;
      end
    end
  end

  for (genvar gi = 0; gi < DW; gi++) begin : g_patch
    assign rdata[gi] = (patch_q && (patch_bit_q == BIT_W'(gi))) ? patch_val_q
                                                                : rd_raw_q[gi];
  end

endmodule

// File: rtl/sram_drf_checker.sv
module sram_drf_checker
  import sram_drf_pkg::*;
#(
  parameter int THR = 3,
  localparam int CW = $clog2(THR + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_we,
  input logic          flt_en,
  input logic          rvalid,
  input drf_event_e    ev_w,
  input logic          armed_w,
  input logic [CW-1:0] cnt_w,
  input logic          corrupt_w
);

  p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> rvalid);

  p_rvalid_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_we) |=> !rvalid);

  p_foreign_row_disarms_r7: assert property (@(posedge clk) disable iff (rst)
    (flt_en && ev_w == EV_FOREIGN_ROW) |=> (!armed_w && cnt_w == '0));

  p_flip_needs_stress_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(corrupt_w) |-> $past(armed_w && cnt_w == CW'(THR - 1) && ev_w == EV_ROW_STRESS));

  p_cnt_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_w < CW'(THR));

  p_rewrite_heals_r9: assert property (@(posedge clk) disable iff (rst)
    (flt_en && ev_w == EV_CELL_WRITE) |=> !corrupt_w);

  p_disable_clears_r10: assert property (@(posedge clk) disable iff (rst)
    !flt_en |=> (!corrupt_w && !armed_w));

endmodule

bind sram_drf_array sram_drf_checker #(.THR(THR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_we    (req_we),
  .flt_en    (flt_en),
  .rvalid    (rvalid),
  .ev_w      (ev_w),
  .armed_w   (armed_w),
  .cnt_w     (cnt_w),
  .corrupt_w (corrupt_w)
);

// File: tb/sram_drf_array_tb.sv
module sram_drf_array_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RB = 2;
  localparam int CB = 2;
  localparam int DW = 4;
  localparam int AW = RB + CB;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          flt_en, flt_pol;
  logic [RB-1:0] flt_row;
  logic [CB-1:0] flt_col;
  logic [BW-1:0] flt_bit;
  logic          rvalid;
  logic [DW-1:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_drf_array #(.ROW_BITS(RB), .COL_BITS(CB), .DW(DW), .THR(3)) dut_i (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata), .flt_en (flt_en),
    .flt_row (flt_row), .flt_col (flt_col), .flt_bit (flt_bit),
    .flt_pol (flt_pol), .rvalid (rvalid), .rdata (rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    check("R3 rvalid low after write", {3'b0, rvalid}, 4'd0);
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 rvalid after read", {3'b0, rvalid}, 4'd1);
    check(req, rdata, exp);
  endtask

  // Faulty word: row 2, column 1 -> address 9; row-mates 8, 10, 11
  localparam logic [AW-1:0] FA = 4'd9;

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    flt_en = 1'b0; flt_pol = 1'b1; flt_row = 2'd2; flt_col = 2'd1; flt_bit = 2'd2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 rvalid idle after reset", {3'b0, rvalid}, 4'd0);

    // R1 / R2: ideal RAM sweep over every address
    for (int a = 0; a < 16; a++) do_write(AW'(a), DW'((a * 7 + 5) % 16));
    for (int a = 0; a < 16; a++) read_chk("R1 R2 ideal sweep", AW'(a), DW'((a * 7 + 5) % 16));

    // R10: fault disabled, heavy stress has no effect
    do_write(FA, 4'b0100);
    for (int k = 0; k < 5; k++) read_chk("R10 disabled no flip", FA, 4'b0100);

    // R4 / R5 / R9: polarity 1, direct reads
    flt_en = 1'b1; flt_pol = 1'b1;
    @(negedge clk);
    do_write(FA, 4'b0100);
    read_chk("R4 first read intact", FA, 4'b0100);
    read_chk("R4 second read intact", FA, 4'b0100);
    read_chk("R5 third stress returns old", FA, 4'b0100);
    read_chk("R5 flipped after third stress", FA, 4'b0000);
    read_chk("R9 flip persists", FA, 4'b0000);
    do_write(FA, 4'b0100);
    read_chk("R9 rewrite heals", FA, 4'b0100);

    // R6: row-mate accesses count as stress; other bits unaffected (R5)
    do_write(FA, 4'b1110);
    read_chk("R6 row-mate read data", 4'd8, DW'((8 * 7 + 5) % 16));
    do_write(4'd10, 4'b0011);
    read_chk("R6 row-mate read data", 4'd11, DW'((11 * 7 + 5) % 16));
    read_chk("R6 flip via row-mate stress", FA, 4'b1010);
    read_chk("R6 row-mate write stored", 4'd10, 4'b0011);

    // R7: foreign row disarms
    do_write(FA, 4'b1110);
    read_chk("R7 read before clear", FA, 4'b1110);
    read_chk("R7 read before clear", FA, 4'b1110);
    read_chk("R2 foreign row data", 4'd0, DW'(5));
    for (int k = 0; k < 5; k++) read_chk("R7 disarmed by foreign row", FA, 4'b1110);

    // R7: non-sensitive write disarms
    do_write(FA, 4'b1110);
    read_chk("R7 read armed", FA, 4'b1110);
    read_chk("R7 read armed", FA, 4'b1110);
    do_write(FA, 4'b1010);
    for (int k = 0; k < 5; k++) read_chk("R7 disarmed by non-sensitive write", FA, 4'b1010);

    // R8: polarity 0
    flt_pol = 1'b0;
    @(negedge clk);
    do_write(FA, 4'b1010);
    read_chk("R8 row-mate stress", 4'd8, DW'((8 * 7 + 5) % 16));
    read_chk("R8 second stress intact", FA, 4'b1010);
    read_chk("R8 third stress returns old", FA, 4'b1010);
    read_chk("R8 zero-sensitive flip", FA, 4'b1110);

    // R10: disabling removes the inversion
    flt_en = 1'b0;
    @(negedge clk);
    read_chk("R10 disable clears flip", FA, 4'b1010);
    flt_en = 1'b1;
    @(negedge clk);
    read_chk("R10 re-enable stays clean", FA, 4'b1010);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule